// File: doc/BRIEF.md
# Element-Width Register File with Spill-Over

This block is an integer register file of 128 entries of 64 bits each. Software can treat it as a flat run of packed elements of 8, 16, 32 or 64 bits. Each access names three things: a base register, an element width code chosen by an outside table entry (not by the opcode), and an element index supplied by a hardware loop. From these the block finds the bytes of that element. An index larger than the number of elements that fit in one register carries on in sequence into the registers after the base register.

There is one port, which handles one element per cycle. The read is combinational and returns the addressed element zero-extended to 64 bits. The write is synchronous and only touches the byte lanes of that element. Any access whose bytes would reach past the last byte of the file raises an access fault, and the address never wraps back to the start of the file. A faulting write leaves the file unchanged.

Reset is synchronous and clears every register. The block has no state machine. All sequencing belongs to the loop that drives the element index.

Top module: `ewrf_top`

## Requirements
- R1: A cycle with `rst` high clears all registers, so every legal read after it returns 0.
- R2: `elem_width` selects the element size: 0 is 8 bits, 1 is 16, 2 is 32 and 3 is 64. The byte address is base_reg×8 + elem_idx×(size in bytes), and byte address a is byte a%8 of register a/8.
- R3: An element index past the last element of the base register continues into the following registers. For example, base 3, width 8, index 9 is byte 1 of register 4.
- R4: For a legal access, `rd_data` holds the addressed element in its low bits, and every bit above the element width is 0.
- R5: A legal write with `wr_en` high replaces only the bytes of the addressed element. All other bytes of the file keep their values.
- R6: `access_fault` is 1 exactly when byte address + size in bytes > 1024. A faulting access never reaches register 0.
- R7: While `access_fault` is 1, `rd_data` is 0, and a write in that cycle changes no state.
- R8: A write takes effect at the rising clock edge. In the same cycle `rd_data` still shows the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, clears the file |
| base_reg | input | 7 | Base register number |
| elem_width | input | 2 | Element width code |
| elem_idx | input | 8 | Element index from the hardware loop |
| wr_en | input | 1 | Write the element at the next clock edge |
| wr_data | input | 64 | Write element, right-aligned |
| rd_data | output | 64 | Read element, zero-extended |
| access_fault | output | 1 | Access runs past the end of the file |

## Verification
The bench targets the following corner cases:
- **Spill-over for every width.** A design that reduced the index modulo the elements per register would keep rewriting the base register.
- **Last legal element of each width.** Base 127 with the final element is legal, and one more element is a fault. An off-by-one comparison would either fault on the legal access or let the illegal one through.
- **Faulting writes at the top of the file.** Low registers are read back afterwards. A wrapping address would corrupt register 0.
- **Narrow writes inside a wider value.** A write strobe that covered the whole register would zero the neighbouring bytes.
- **A reset in the middle of a run.** A design that skipped some rows during reset would leave stale data.

// File: rtl/ewrf_pkg.sv
package ewrf_pkg;
    localparam int LANES = 8;

    typedef enum logic [1:0] {
        EW_B8  = 2'd0,
        EW_B16 = 2'd1,
        EW_B32 = 2'd2,
        EW_B64 = 2'd3
    } ew_e;

    function automatic logic [3:0] ew_bytes(input ew_e w);
        unique case (w)
            EW_B8:   return 4'd1;
            EW_B16:  return 4'd2;
            EW_B32:  return 4'd4;
            default: return 4'd8;
        endcase
    endfunction

    function automatic logic [LANES-1:0] ew_lanes(input ew_e w);
        unique case (w)
            EW_B8:   return 8'h01;
            EW_B16:  return 8'h03;
            EW_B32:  return 8'h0F;
            default: return 8'hFF;
        endcase
    endfunction
endpackage

// File: rtl/ewrf_locate.sv
module ewrf_locate
    import ewrf_pkg::*;
#(
    parameter int NREGS = 128,
    parameter int IDX_W = 8
) (
    input  logic [$clog2(NREGS)-1:0] base_i,
    input  ew_e                      ew_i,
    input  logic [IDX_W-1:0]         idx_i,
    output logic [$clog2(NREGS)-1:0] row_o,
    output logic [2:0]               off_o,
    output logic [LANES-1:0]         mask_o,
    output logic [3:0]               nbytes_o,
    output logic                     fault_o
);
    localparam int ROW_W      = $clog2(NREGS);
    localparam int FILE_BYTES = NREGS * LANES;
    localparam int ADDR_W     = ROW_W + IDX_W + 4;

    logic [ADDR_W-1:0] byte_addr;
    logic [ADDR_W:0]   end_addr;
    logic [2*LANES-1:0] wide_mask;

    always_comb begin
        nbytes_o  = ew_bytes(ew_i);
        byte_addr = ADDR_W'({base_i, 3'b000}) + (ADDR_W'(idx_i) << ew_i);
        end_addr  = (ADDR_W+1)'(byte_addr) + (ADDR_W+1)'(nbytes_o);
        fault_o   = end_addr > (ADDR_W+1)'(FILE_BYTES);
        row_o     = byte_addr[ROW_W+2:3];
        off_o     = byte_addr[2:0];
        wide_mask = {8'h00, ew_lanes(ew_i)} << off_o;
        mask_o    = fault_o ? '0 : wide_mask[LANES-1:0];
    end

    // A legal access must sit inside one real register of the file.
    always_comb begin
        if (!fault_o) begin
            assert_inside_file_R6: assert (int'(byte_addr[ADDR_W-1:3]) < NREGS
                                           && int'(off_o) + int'(nbytes_o) <= LANES);
            assert_lane_count_R5: assert ($countones(mask_o) == int'(nbytes_o));
        end
    end
endmodule

// File: rtl/ewrf_align.sv
module ewrf_align
    import ewrf_pkg::*;
(
    input  ew_e         ew_i,
    input  logic [2:0]  off_i,
    input  logic        fault_i,
    input  logic [63:0] row_data_i,
    input  logic [63:0] wr_elem_i,
    output logic [63:0] rd_elem_o,
    output logic [63:0] wr_lane_o
);
    logic [63:0] shifted;

    always_comb begin
        shifted = row_data_i >> {off_i, 3'b000};
        unique case (ew_i)
            EW_B8:   rd_elem_o = {56'd0, shifted[7:0]};
            EW_B16:  rd_elem_o = {48'd0, shifted[15:0]};
            EW_B32:  rd_elem_o = {32'd0, shifted[31:0]};
            default: rd_elem_o = shifted;
        endcase
        if (fault_i) rd_elem_o = '0;
        wr_lane_o = wr_elem_i << {off_i, 3'b000};
    end
endmodule

// File: rtl/ewrf_store.sv
module ewrf_store
    import ewrf_pkg::*;
#(
    parameter int NREGS = 128
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     we_i,
    input  logic [$clog2(NREGS)-1:0] row_i,
    input  logic [LANES-1:0]         mask_i,
    input  logic [63:0]              wdata_i,
    output logic [63:0]              rdata_o
);
    logic [63:0]      mem    [NREGS];
    logic [NREGS-1:0] row_we;

    assign rdata_o = mem[row_i];

    for (genvar r = 0; r < NREGS; r++) begin : g_row
        assign row_we[r] = we_i && (int'(row_i) == r) && (mask_i != '0);

        always_ff @(posedge clk) begin
            if (rst) begin
                mem[r] <= '0;
            end else if (row_we[r]) begin
                for (int b = 0; b < LANES; b++) begin
                    if (mask_i[b]) mem[r][8*b +: 8] <= wdata_i[8*b +: 8];
                end
            end
        end

        // Rows not selected for a write keep their contents.
        assert_row_hold_R5: assert property (@(posedge clk) disable iff (rst)
            !row_we[r] |=> $stable(mem[r]));
    end
endmodule

// File: rtl/ewrf_top.sv
module ewrf_top
    import ewrf_pkg::*;
#(
    parameter int NREGS = 128,
    parameter int IDX_W = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [$clog2(NREGS)-1:0] base_reg,
    input  logic [1:0]               elem_width,
    input  logic [IDX_W-1:0]         elem_idx,
    input  logic                     wr_en,
    input  logic [63:0]              wr_data,
    output logic [63:0]              rd_data,
    output logic                     access_fault
);
    localparam int ROW_W = $clog2(NREGS);

    ew_e              ew;
    logic [ROW_W-1:0] row;
    logic [2:0]       off;
    logic [LANES-1:0] mask;
    logic [3:0]       nbytes;
    logic [63:0]      row_data;
    logic [63:0]      wr_lane;

    assign ew = ew_e'(elem_width);

    ewrf_locate #(.NREGS(NREGS), .IDX_W(IDX_W)) u_locate (
        .base_i(base_reg), .ew_i(ew), .idx_i(elem_idx),
        .row_o(row), .off_o(off), .mask_o(mask),
        .nbytes_o(nbytes), .fault_o(access_fault)
    );

    ewrf_store #(.NREGS(NREGS)) u_store (
        .clk(clk), .rst(rst), .we_i(wr_en && !access_fault),
        .row_i(row), .mask_i(mask), .wdata_i(wr_lane), .rdata_o(row_data)
    );

    ewrf_align u_align (
        .ew_i(ew), .off_i(off), .fault_i(access_fault),
        .row_data_i(row_data), .wr_elem_i(wr_data),
        .rd_elem_o(rd_data), .wr_lane_o(wr_lane)
    );

    assert_zero_ext_R4: assert property (@(posedge clk) disable iff (rst)
        (!access_fault && nbytes != 4'd8) |-> ((rd_data >> {nbytes, 3'b000}) == 64'd0));

    assert_fault_silent_R7: assert property (@(posedge clk) disable iff (rst)
        access_fault |-> (rd_data == 64'd0 && mask == '0));
endmodule

// File: tb/ewrf_top_test.sv
module ewrf_top_test;
    logic        clk = 1'b0;
    logic        rst;
    logic [6:0]  base_reg;
    logic [1:0]  elem_width;
    logic [7:0]  elem_idx;
    logic        wr_en;
    logic [63:0] wr_data;
    logic [63:0] rd_data;
    logic        access_fault;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    byte unsigned model [1024];

    always #5 clk = ~clk;

    ewrf_top uut (
        .clk(clk), .rst(rst), .base_reg(base_reg), .elem_width(elem_width),
        .elem_idx(elem_idx), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .access_fault(access_fault)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one access, compare against the byte model before the edge,
    // then let the model take the write that the edge will commit.
    task automatic op(input int b, input int w, input int i, input bit we,
                      input logic [63:0] d, input string tag);
        int nb = 1 << w;
        int a  = b * 8 + i * nb;
        bit f  = (a + nb) > 1024;
        logic [63:0] exp = '0;
        @(negedge clk);
        base_reg = 7'(b); elem_width = 2'(w); elem_idx = 8'(i);
        wr_en = we; wr_data = d;
        #1;
        if (!f) for (int k = 0; k < nb; k++) exp |= 64'(model[a + k]) << (8 * k);
        check({tag, " fault"}, 64'(access_fault), 64'(f));
        check({tag, " data"}, rd_data, exp);
        if (we && !f) for (int k = 0; k < nb; k++) model[a + k] = d[8*k +: 8];
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; wr_en = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        for (int k = 0; k < 1024; k++) model[k] = 8'h00;
    endtask

    initial begin
        rst = 1'b1; wr_en = 1'b0; base_reg = '0; elem_width = '0;
        elem_idx = '0; wr_data = '0;
        repeat (3) @(negedge clk);
        do_reset();
        // R1: everything clear after reset
        op(0, 3, 0, 0, 0, "R1 reg0");
        op(127, 3, 0, 0, 0, "R1 reg127");
        op(64, 0, 5, 0, 0, "R1 byte");
        // R2 / R4: 64-bit write viewed as narrower elements
        op(10, 3, 0, 1, 64'h8877_6655_4433_2211, "R2 wr64");
        op(10, 1, 2, 0, 0, "R2 half2");
        op(10, 0, 7, 0, 0, "R4 byte7");
        op(10, 2, 1, 0, 0, "R4 word1");
        // R3: spill into following registers for each width
        op(3, 0, 9, 1, 64'hFFFF_FFFF_FFFF_FFA5, "R3 byte spill");
        op(4, 3, 0, 0, 0, "R3 reg4 view");
        op(3, 1, 13, 1, 64'hBEEF, "R3 half spill");
        op(3, 2, 5, 1, 64'hCAFE_F00D, "R3 word spill");
        op(5, 3, 0, 0, 0, "R3 reg5 view");
        op(3, 3, 4, 1, 64'h0123_4567_89AB_CDEF, "R3 dword spill");
        op(7, 3, 0, 0, 0, "R3 reg7 view");
        // R5: narrow write inside a full register
        op(20, 3, 0, 1, 64'hAAAA_AAAA_AAAA_AAAA, "R5 fill");
        op(20, 0, 3, 1, 64'h55, "R5 byte3");
        op(20, 3, 0, 0, 0, "R5 neighbours");
        // R6: top-of-file boundaries for each width
        for (int w = 0; w < 4; w++) begin
            op(127, w, (8 >> w) - 1, 1, 64'h1111_2222_3333_4444, "R6 last legal");
            op(127, w, 8 >> w, 0, 0, "R6 first illegal");
        end
        op(0, 3, 128, 0, 0, "R6 idx past file");
        // R7: faulting writes leave low registers alone
        op(127, 3, 1, 1, 64'hDEAD_DEAD_DEAD_DEAD, "R7 fault wr");
        op(100, 0, 255, 1, 64'hEE, "R7 fault wr far");
        op(0, 3, 0, 0, 0, "R7 reg0 intact");
        op(127, 3, 0, 0, 0, "R7 reg127 intact");
        // R8: write and read same element back to back
        op(50, 2, 0, 1, 64'h1234_5678, "R8 write");
        op(50, 2, 0, 1, 64'h9ABC_DEF0, "R8 old seen");
        op(50, 2, 0, 0, 0, "R8 new seen");
        // mixed traffic, biased to the upper file
        for (int n = 0; n < 3000; n++) begin
            int b = 96 + int'($urandom_range(0, 31));
            int w = int'($urandom_range(0, 3));
            int i = int'($urandom_range(0, 40));
            op(b, w, i, 1'($urandom_range(0, 1)), {$urandom, $urandom}, "R8 mixed");
        end
        // R1: reset in the middle of a run
        do_reset();
        for (int r = 96; r < 128; r++) op(r, 3, 0, 0, 0, "R1 after rerun");
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule